// File: doc/BRIEF.md
# Cache Line Fill Read Controller

This block is the bus master that fills one 16-byte cache line with four 32-bit words. A cache hands it a single line-read request made of an address and a flag that marks the request as an instruction fetch. The controller places one address and tries a burst, in which the memory acknowledges the four words one after another. Memory that cannot burst answers the first word with a burst-inhibit flag. The controller then completes the line with three separate single-word read cycles, and each of those cycles has its own address and its own start strobe.

The order of the words wraps inside the line, starting at the requested word and stepping up one word at a time modulo four. Every returned word carries its index within the line. For an instruction fetch the line starts at the half-line boundary that holds the target, and a critical-ready pulse marks the return of the second word, which is the one the pipeline waits for. A cache-inhibit flag sampled on the first word is kept and reported when the line completes. The controller holds the bus for the whole line, and it accepts a new request only once the line is complete.

Top module: `line_fill_ctrl`

## Requirements
- R1: A request is taken only when `req_ready` is high. Each accepted request returns exactly four words. `rd_valid` is high for one cycle after each clock edge at which `bus_ack` is sampled high, and it stays low during wait cycles. `req_ready` is low while the line is in progress.
- R2: In burst mode `bus_burst` is high and `bus_addr` holds the first address for every word of the line.
- R3: The word index starts at the first word and steps up by one modulo four. `rd_index` reports the 2-bit index (address bits 3..2) of each returned word.
- R4: If `bus_burst_inh` is high at the first acknowledge, `bus_burst` drops and each of the remaining three words gets its own one-cycle `bus_start` pulse, with address bits 3..2 set to that word's wrapped index. `bus_start` is high only in the first cycle of each bus cycle.
- R5: `bus_burst_inh` sampled on the second, third or fourth acknowledge has no effect. The burst continues with no new strobe.
- R6: `bus_cache_inh` sampled at the first acknowledge appears on `done_nocache` together with `done`. It does not shorten the line. Later samples of it are ignored.
- R7: On a data read, `bus_addr[1:0]` equals the requested address bits 1..0 in every cycle of the line, fallback cycles included.
- R8: On an instruction fetch, the first address has bits 2..0 equal to zero and bit 3 taken from the request, so bits 3..0 read either 0x0 or 0x8.
- R9: On an instruction fetch, `crit_ready` pulses together with `rd_valid` of the second returned word. On a data read it never rises.
- R10: `bus_lock` stays high from acceptance until the fourth acknowledge is sampled. `done` then pulses for one cycle, in the cycle where `bus_lock` has dropped and `req_ready` is high again.
- R11: After reset, `req_ready` is high and `bus_lock`, `bus_start`, `bus_burst`, `rd_valid`, `crit_ready` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Line-read request |
| req_addr | input | ADDR_W | Requested operand address |
| req_ifetch | input | 1 | Request is an instruction fetch |
| req_ready | output | 1 | Controller idle, request may be taken |
| bus_addr | output | ADDR_W | Bus address |
| bus_start | output | 1 | Transfer-start strobe |
| bus_burst | output | 1 | Burst requested |
| bus_lock | output | 1 | Bus held for the line |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_burst_inh | input | 1 | Memory cannot burst |
| bus_cache_inh | input | 1 | Line must not be cached |
| bus_data | input | DATA_W | Read data |
| rd_valid | output | 1 | Returned word valid |
| rd_data | output | DATA_W | Returned word |
| rd_index | output | 2 | Word index within the line |
| crit_ready | output | 1 | Critical word available |
| done | output | 1 | Line complete |
| done_nocache | output | 1 | Latched cache-inhibit, valid with done |

## Verification
The bench builds the block with its defaults, a 32-bit address and a 32-bit data path. The full-width address lets the bench check that the high address bits pass through unchanged while bits 3..2 wrap and bits 1..0 stay fixed. The 32-bit data lets each returned word carry a line tag and its index, so a word returned out of order or taken from the wrong beat is visible. The requests mix burst and fallback lines, data reads and instruction fetches, different wait-state counts, and inhibit flags raised on the first beat and on later beats.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int LINE_WORDS = 4;
  localparam int IDX_W      = $clog2(LINE_WORDS);

  typedef logic [IDX_W-1:0] word_idx_t;

  // advance to the next word of the line, wrapping at the line end
  function automatic word_idx_t wrap_next(input word_idx_t i);
    return i + word_idx_t'(1);
  endfunction
endpackage

// File: rtl/lfc_seq.sv
module lfc_seq
  import lfc_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int HI_W  = ADDR_W - 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic            req_ifetch,
  input  logic            bus_ack,
  input  logic            bus_burst_inh,
  input  logic            bus_cache_inh,
  output logic            busy,
  output logic            start_q,
  output logic            fb_q,
  output logic            ifetch_q,
  output logic            ci_q,
  output logic [HI_W-1:0] hi_q,
  output logic [1:0]      lo_q,
  output word_idx_t       first_idx_q,
  output word_idx_t       cur_idx_q,
  output word_idx_t       cnt_q,
  output logic            beat_fire,
  output logic            last_beat
);
  logic      busy_d, start_d, fb_d, ci_d, accept;
  word_idx_t cnt_d, cur_idx_d, first_idx_d;

  assign accept    = !busy && req_valid;
  assign beat_fire = busy && bus_ack;
  assign last_beat = (cnt_q == word_idx_t'(LINE_WORDS - 1));
  assign first_idx_d = req_ifetch ? {req_addr[3], 1'b0} : req_addr[3:2];

  always_comb begin
    busy_d    = busy;
    start_d   = 1'b0;
    fb_d      = fb_q;
    ci_d      = ci_q;
    cnt_d     = cnt_q;
    cur_idx_d = cur_idx_q;
    if (accept) begin
      busy_d    = 1'b1;
      start_d   = 1'b1;
      fb_d      = 1'b0;
      ci_d      = 1'b0;
      cnt_d     = '0;
      cur_idx_d = first_idx_d;
    end else if (beat_fire) begin
      if (cnt_q == '0) begin
        fb_d = bus_burst_inh;
        ci_d = bus_cache_inh;
      end
      if (last_beat) begin
        busy_d = 1'b0;
      end else begin
        cnt_d     = cnt_q + word_idx_t'(1);
        cur_idx_d = wrap_next(cur_idx_q);
        start_d   = fb_q || ((cnt_q == '0) && bus_burst_inh);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      start_q   <= 1'b0;
      fb_q      <= 1'b0;
      ci_q      <= 1'b0;
      cnt_q     <= '0;
      cur_idx_q <= '0;
    end else begin
      busy      <= busy_d;
      start_q   <= start_d;
      fb_q      <= fb_d;
      ci_q      <= ci_d;
      cnt_q     <= cnt_d;
      cur_idx_q <= cur_idx_d;
    end
  end

  // request fields are captured only when a request is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifetch_q    <= 1'b0;
      hi_q        <= '0;
      lo_q        <= '0;
      first_idx_q <= '0;
    end else if (accept) begin
      ifetch_q    <= req_ifetch;
      hi_q        <= req_addr[ADDR_W-1:4];
      lo_q        <= req_ifetch ? 2'b00 : req_addr[1:0];
      first_idx_q <= first_idx_d;
    end
  end

  // R5
  fb_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_q) |-> ($past(cnt_q) == '0) && $past(bus_ack));

  // R10
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bus_ack) && ($past(cnt_q) == word_idx_t'(LINE_WORDS - 1)));

  // R4
  start_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> busy);
endmodule

// File: rtl/lfc_addr.sv
module lfc_addr
  import lfc_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int HI_W  = ADDR_W - 4
) (
  input  logic [HI_W-1:0]   hi,
  input  logic [1:0]        lo,
  input  word_idx_t         first_idx,
  input  word_idx_t         cur_idx,
  input  logic              fallback,
  output logic [ADDR_W-1:0] addr
);
  word_idx_t sel_idx;

  // a burst keeps its single address; fallback cycles address each word
  assign sel_idx = fallback ? cur_idx : first_idx;
  assign addr    = {hi, sel_idx, lo};
endmodule

// File: rtl/lfc_resp.sv
module lfc_resp
  import lfc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_fire,
  input  logic              last_beat,
  input  logic              ifetch,
  input  logic              ci_latched,
  input  word_idx_t         cnt,
  input  word_idx_t         cur_idx,
  input  logic [DATA_W-1:0] bus_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output word_idx_t         rd_index,
  output logic              crit_ready,
  output logic              done,
  output logic              done_nocache
);
  logic crit_d, done_d, nocache_d;

  assign crit_d    = beat_fire && ifetch && (cnt == word_idx_t'(1));
  assign done_d    = beat_fire && last_beat;
  assign nocache_d = done_d && ci_latched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      crit_ready   <= 1'b0;
      done         <= 1'b0;
      done_nocache <= 1'b0;
    end else begin
      rd_valid     <= beat_fire;
      crit_ready   <= crit_d;
      done         <= done_d;
      done_nocache <= nocache_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_index <= '0;
    end else if (beat_fire) begin
      rd_data  <= bus_data;
      rd_index <= cur_idx;
    end
  end

  // R9
  crit_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crit_ready |-> rd_valid);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  nocache_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_nocache |-> done);
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
  import lfc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_ifetch,
  output logic              req_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_start,
  output logic              bus_burst,
  output logic              bus_lock,
  input  logic              bus_ack,
  input  logic              bus_burst_inh,
  input  logic              bus_cache_inh,
  input  logic [DATA_W-1:0] bus_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_index,
  output logic              crit_ready,
  output logic              done,
  output logic              done_nocache
);
  localparam int HI_W = ADDR_W - 4;

  logic            busy, start_q, fb_q, ifetch_q, ci_q, beat_fire, last_beat;
  logic [HI_W-1:0] hi_q;
  logic [1:0]      lo_q;
  word_idx_t       first_idx_q, cur_idx_q, cnt_q;

  lfc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ifetch(req_ifetch),
    .bus_ack(bus_ack), .bus_burst_inh(bus_burst_inh), .bus_cache_inh(bus_cache_inh),
    .busy(busy), .start_q(start_q), .fb_q(fb_q), .ifetch_q(ifetch_q), .ci_q(ci_q),
    .hi_q(hi_q), .lo_q(lo_q), .first_idx_q(first_idx_q), .cur_idx_q(cur_idx_q),
    .cnt_q(cnt_q), .beat_fire(beat_fire), .last_beat(last_beat)
  );

  lfc_addr #(.ADDR_W(ADDR_W)) u_addr (
    .hi(hi_q), .lo(lo_q), .first_idx(first_idx_q), .cur_idx(cur_idx_q),
    .fallback(fb_q), .addr(bus_addr)
  );

  lfc_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .beat_fire(beat_fire), .last_beat(last_beat), .ifetch(ifetch_q),
    .ci_latched(ci_q), .cnt(cnt_q), .cur_idx(cur_idx_q), .bus_data(bus_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_index(rd_index),
    .crit_ready(crit_ready), .done(done), .done_nocache(done_nocache)
  );

  assign req_ready = !busy;
  assign bus_lock  = busy;
  assign bus_start = start_q;
  assign bus_burst = busy && !fb_q;

  // R7
  low_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock && $past(bus_lock) |-> bus_addr[1:0] == $past(bus_addr[1:0]));

  // R2
  burst_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_burst && $past(bus_burst) |-> $stable(bus_addr));

  // R5
  no_burst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock && $past(bus_lock) |-> !$rose(bus_burst));
endmodule

// File: tb/line_fill_ctrl_bench.sv
module line_fill_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ifetch, req_ready;
  logic [31:0] req_addr, bus_addr, bus_data, rd_data;
  logic        bus_start, bus_burst, bus_lock, bus_ack, bus_burst_inh, bus_cache_inh;
  logic        rd_valid, crit_ready, done, done_nocache;
  logic [1:0]  rd_index;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  line_fill_ctrl u_line_fill_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ifetch(req_ifetch),
    .req_ready(req_ready), .bus_addr(bus_addr), .bus_start(bus_start),
    .bus_burst(bus_burst), .bus_lock(bus_lock), .bus_ack(bus_ack),
    .bus_burst_inh(bus_burst_inh), .bus_cache_inh(bus_cache_inh), .bus_data(bus_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_index(rd_index),
    .crit_ready(crit_ready), .done(done), .done_nocache(done_nocache)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // One line fill with a behavioural memory model and expected values.
  task automatic run_line(input logic [31:0] addr, input bit ifetch, input bit bi0,
                          input bit ci0, input bit noise, input int waits,
                          input logic [7:0] tagno);
    logic [1:0] first, idx, low;
    logic [31:0] exp_addr, word;
    int order[$];
    first = ifetch ? {addr[3], 1'b0} : addr[3:2];
    low   = ifetch ? 2'b00 : addr[1:0];
    for (int k = 0; k < 4; k++) order.push_back(int'((first + 2'(k)) & 2'b11));

    chk(req_ready === 1'b1, "R1 ready before request", 32'(req_ready), 32'd1);
    req_valid  = 1'b1;
    req_addr   = addr;
    req_ifetch = ifetch;
    @(negedge clk);
    req_valid = 1'b0;

    for (int b = 0; b < 4; b++) begin
      bit fbmode;
      idx      = 2'(order[b]);
      fbmode   = bi0 && (b > 0);
      exp_addr = {addr[31:4], fbmode ? idx : first, low};
      chk(bus_lock === 1'b1, "R10 lock held", 32'(bus_lock), 32'd1);
      chk(req_ready === 1'b0, "R1 busy not ready", 32'(req_ready), 32'd0);
      chk(bus_addr === exp_addr, fbmode ? "R4 fallback addr" : "R2 burst addr",
          bus_addr, exp_addr);
      chk(bus_addr[1:0] === low, "R7 low bits", 32'(bus_addr[1:0]), 32'(low));
      if (ifetch && b == 0)
        chk(bus_addr[2:0] === 3'b000 && bus_addr[3] === addr[3], "R8 half-line start",
            bus_addr, {addr[31:3], 3'b000});
      chk(bus_start === ((b == 0) || fbmode), "R4 start strobe", 32'(bus_start),
          32'((b == 0) || fbmode));
      chk(bus_burst === !fbmode, noise ? "R5 burst kept" : "R4 burst flag",
          32'(bus_burst), 32'(!fbmode));
      for (int w = 0; w < waits; w++) begin
        bus_ack = 1'b0;
        @(negedge clk);
        chk(rd_valid === 1'b0, "R1 no data in wait", 32'(rd_valid), 32'd0);
        chk(bus_start === 1'b0, "R4 strobe one cycle", 32'(bus_start), 32'd0);
        chk(bus_addr === exp_addr, "R2 addr held in wait", bus_addr, exp_addr);
      end
      word          = {tagno, 8'h5A, 14'h0, idx};
      bus_ack       = 1'b1;
      bus_data      = word;
      bus_burst_inh = (b == 0) ? bi0 : noise;
      bus_cache_inh = (b == 0) ? ci0 : noise;
      @(negedge clk);
      bus_ack       = 1'b0;
      bus_burst_inh = 1'b0;
      bus_cache_inh = 1'b0;
      chk(rd_valid === 1'b1, "R1 data valid", 32'(rd_valid), 32'd1);
      chk(rd_index === idx, "R3 wrapped index", 32'(rd_index), 32'(idx));
      chk(rd_data === word, "R3 returned word", rd_data, word);
      chk(crit_ready === (ifetch && b == 1), "R9 critical pulse", 32'(crit_ready),
          32'(ifetch && b == 1));
      chk(done === (b == 3), "R10 done timing", 32'(done), 32'(b == 3));
      if (b == 3)
        chk(done_nocache === ci0, "R6 cache-inhibit report", 32'(done_nocache), 32'(ci0));
    end
    chk(bus_lock === 1'b0, "R10 lock released", 32'(bus_lock), 32'd0);
    chk(req_ready === 1'b1, "R10 ready after done", 32'(req_ready), 32'd1);
  endtask

  initial begin
    rst_n         = 1'b0;
    req_valid     = 1'b0;
    req_addr      = '0;
    req_ifetch    = 1'b0;
    bus_ack       = 1'b0;
    bus_burst_inh = 1'b0;
    bus_cache_inh = 1'b0;
    bus_data      = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready === 1'b1, "R11 ready", 32'(req_ready), 32'd1);
    chk(bus_lock === 1'b0, "R11 lock", 32'(bus_lock), 32'd0);
    chk(bus_start === 1'b0, "R11 start", 32'(bus_start), 32'd0);
    chk(bus_burst === 1'b0, "R11 burst", 32'(bus_burst), 32'd0);
    chk(rd_valid === 1'b0 && crit_ready === 1'b0 && done === 1'b0, "R11 outputs",
        {29'd0, rd_valid, crit_ready, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && bus_lock === 1'b0, "R11 after release",
        {30'd0, req_ready, bus_lock}, 32'd2);

    run_line(32'h1000_0006, 1'b0, 1'b0, 1'b0, 1'b0, 0, 8'h01); // data burst, R7
    run_line(32'h1000_000C, 1'b1, 1'b0, 1'b0, 1'b0, 1, 8'h02); // fetch 8,C,0,4, R8 R9
    run_line(32'h2000_0009, 1'b0, 1'b1, 1'b1, 1'b0, 2, 8'h03); // fallback, R4 R6
    run_line(32'h0000_0004, 1'b1, 1'b0, 1'b0, 1'b1, 0, 8'h04); // late inhibits, R5 R6
    run_line(32'h3000_0008, 1'b1, 1'b1, 1'b0, 1'b1, 1, 8'h05); // fetch fallback
    @(negedge clk);
    run_line(32'hFFFF_FFF3, 1'b0, 1'b1, 1'b0, 1'b0, 0, 8'h06); // fallback at top of space

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule